// File: doc/BRIEF.md
# Serial Command/Data Byte Framer

This block receives a write-only serial stream for a display controller and turns it into whole bytes, each tagged as either a command or a display-data byte. The host drives a serial clock, a serial data line and an active-low select. In four-wire operation it also drives a register-select line that tags every byte directly. All serial inputs are synchronized into the system clock domain. The serial clock is then edge-detected there, so the serial clock must run well below the system clock. Each rising serial edge captures one bit, most significant bit first.

In three-wire operation there is no register-select line, so every byte counts as a command unless the host opens a data run. It does this with a fixed direction byte (0xE8) followed by a length byte L. The next L+1 bytes are then reported as display data, and the framer returns to command mode by itself. Every display-data byte also raises a column-advance pulse for the address logic downstream.

Top module: `serial_cmd_framer`

## Requirements
- R1: While select is low, each group of eight rising serial-clock edges yields exactly one `byte_vld` pulse of one system cycle, with `byte_data` holding the sampled bits, the first one sampled in bit 7.
- R2: Select high clears the partly assembled byte and the bit count. Bits sent before select went high never appear, and the next byte after select returns low is assembled from fresh bits.
- R3: With `four_pin` = 1, the register-select level sampled with the eighth bit sets `byte_is_data`: 1 means display data and 0 means command. The value 0xE8 has no special meaning in this mode.
- R4: With `four_pin` = 0, a byte is a command (`byte_is_data` = 0) unless a data run is open, and the `rs` input has no effect.
- R5: With `four_pin` = 0, a command byte equal to 0xE8 makes the following byte a length byte L. Both bytes are reported as commands, and the next L+1 bytes are reported as display data.
- R6: A length byte of 127 or more gives a run of exactly 128 data bytes.
- R7: The byte after the last byte of a run is a command again; a length of 0 gives a run of one byte.
- R8: `col_inc` pulses in the same cycle as `byte_vld` for each display-data byte, and at no other time.
- R9: Select going high during a length byte or a data run ends the run, and the next byte is a command.
- R10: After reset, all outputs are low and the framer is in command mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| four_pin | input | 1 | 1: register-select line tags bytes; 0: counted data runs |
| sclk | input | 1 | Serial clock, sampled asynchronously |
| sdi | input | 1 | Serial data, most significant bit first |
| cs_n | input | 1 | Active-low select |
| rs | input | 1 | Register select, 1 = display data (four-wire only) |
| byte_vld | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Completed byte |
| byte_is_data | output | 1 | Tag of the completed byte, 1 = display data |
| col_inc | output | 1 | Column-advance pulse for each display-data byte |

## Verification
The bench targets the edges of the run length. A length of 0 must give a single data byte, 127 must give 128, and 255 must be clamped to 128. An off-by-one counter would tag one byte too many or too few, and a missing clamp would keep the framer in data mode long after the host had gone back to commands. The bench also drops select in the middle of a byte and in the middle of a run. A framer that kept stale bits would deliver a shifted byte, and one that kept its run state would tag the next command as data. Mixed four-wire patterns check that 0xE8 opens no run there, and that `rs` is ignored in three-wire mode.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int RUN_MAX = 128;
    localparam int RUN_W = $clog2(RUN_MAX + 1);
    localparam logic [BYTE_W-1:0] DIR_OPEN = 8'hE8;

    typedef enum logic [1:0] {
        FR_CMD,
        FR_LEN,
        FR_RUN
    } fr_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] value;
        logic              rs;
    } rx_byte_t;

    // Number of data bytes a length byte opens: L+1, clamped to RUN_MAX.
    function automatic logic [RUN_W-1:0] run_len(input logic [BYTE_W-1:0] l);
        if (int'(l) >= RUN_MAX - 1)
            return RUN_W'(RUN_MAX);
        return RUN_W'(l) + RUN_W'(1);
    endfunction
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < STAGES; g++) begin : g_st
        logic [W-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= g_st[g-1].r;
            end
        end
    end

    assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter
    import sfr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_s,
    input  logic     sdi_s,
    input  logic     cs_n_s,
    input  logic     rs_s,
    output logic     rdy,
    output rx_byte_t rx
);
    logic                 sclk_q;
    logic [BYTE_W-1:0]    sh;
    logic [BIT_CNT_W-1:0] cnt;
    logic                 rise;

    assign rise = sclk_s & ~sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sh     <= '0;
            cnt    <= '0;
            rdy    <= 1'b0;
            rx     <= '0;
        end else begin
            sclk_q <= sclk_s;
            rdy    <= 1'b0;
            if (cs_n_s) begin
                sh  <= '0;
                cnt <= '0;
            end else if (rise) begin
                sh  <= {sh[BYTE_W-2:0], sdi_s};
                cnt <= cnt + BIT_CNT_W'(1);
                if (cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                    rdy      <= 1'b1;
                    rx.value <= {sh[BYTE_W-2:0], sdi_s};
                    rx.rs    <= rs_s;
                end
            end
        end
    end

    // R2: a deasserted select leaves no bit count behind
    a_r2_cs_clears: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (cnt == '0));

    // R1: a completed byte is a single-cycle strobe
    a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy);
endmodule

// File: rtl/sfr_classifier.sv
module sfr_classifier
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              four_pin,
    input  logic              cs_n_s,
    input  logic              rdy,
    input  rx_byte_t          rx,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_is_data,
    output logic              col_inc
);
    fr_state_e        state;
    logic [RUN_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= FR_CMD;
            left         <= '0;
            byte_vld     <= 1'b0;
            byte_data    <= '0;
            byte_is_data <= 1'b0;
            col_inc      <= 1'b0;
        end else begin
            byte_vld <= rdy;
            col_inc  <= 1'b0;
            if (rdy) begin
                byte_data <= rx.value;
                if (four_pin) begin
                    byte_is_data <= rx.rs;
                    col_inc      <= rx.rs;
                    state        <= FR_CMD;
                end else begin
                    unique case (state)
                        FR_CMD: begin
                            byte_is_data <= 1'b0;
                            if (rx.value == DIR_OPEN) state <= FR_LEN;
                        end
                        FR_LEN: begin
                            byte_is_data <= 1'b0;
                            left         <= run_len(rx.value);
                            state        <= FR_RUN;
                        end
                        FR_RUN: begin
                            byte_is_data <= 1'b1;
                            col_inc      <= 1'b1;
                            left         <= left - RUN_W'(1);
                            if (left == RUN_W'(1)) state <= FR_CMD;
                        end
                        default: state <= FR_CMD;
                    endcase
                end
            end
            if (cs_n_s) begin
                state <= FR_CMD;
                left  <= '0;
            end
        end
    end

    // R7: an open run always has bytes left to deliver
    a_r7_run_nonzero: assert property (@(posedge clk) disable iff (rst)
        (state == FR_RUN) |-> (left != '0));

    // R6: the run counter never exceeds the clamp
    a_r6_len_bound: assert property (@(posedge clk) disable iff (rst)
        int'(left) <= RUN_MAX);

    // R9: deselect returns the framer to command mode
    a_r9_cs_exit: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (state == FR_CMD));

    // R8: column advance only accompanies a delivered data byte
    a_r8_col_with_data: assert property (@(posedge clk) disable iff (rst)
        col_inc |-> (byte_vld && byte_is_data));
endmodule

// File: rtl/serial_cmd_framer.sv
module serial_cmd_framer
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              four_pin,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              cs_n,
    input  logic              rs,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_is_data,
    output logic              col_inc
);
    localparam int SYNC_STAGES = 2;

    logic [3:0] raw_in;
    logic [3:0] syn;
    logic       rdy;
    rx_byte_t   rx;

    assign raw_in = {cs_n, rs, sdi, sclk};

    sfr_sync #(
        .W      (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1000)
    ) sync_i (
        .clk(clk),
        .rst(rst),
        .d  (raw_in),
        .q  (syn)
    );

    sfr_shifter shift_i (
        .clk   (clk),
        .rst   (rst),
        .sclk_s(syn[0]),
        .sdi_s (syn[1]),
        .cs_n_s(syn[3]),
        .rs_s  (syn[2]),
        .rdy   (rdy),
        .rx    (rx)
    );

    sfr_classifier class_i (
        .clk         (clk),
        .rst         (rst),
        .four_pin    (four_pin),
        .cs_n_s      (syn[3]),
        .rdy         (rdy),
        .rx          (rx),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .byte_is_data(byte_is_data),
        .col_inc     (col_inc)
    );

    // R1: every output strobe follows a byte completed by the shifter
    a_r1_vld_follows_rdy: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(rdy));
endmodule

// File: tb/serial_cmd_framer_tb_top.sv
module serial_cmd_framer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       four_pin = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       cs_n = 1'b1;
    logic       rs = 1'b0;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       byte_is_data;
    logic       col_inc;

    int checks = 0;
    int errors = 0;
    int cap_n = 0;
    int col_n = 0;
    logic [7:0] cap_b [512];
    logic       cap_d [512];

    always #4 clk = ~clk;

    serial_cmd_framer dut_i (
        .clk(clk), .rst(rst), .four_pin(four_pin), .sclk(sclk), .sdi(sdi),
        .cs_n(cs_n), .rs(rs), .byte_vld(byte_vld), .byte_data(byte_data),
        .byte_is_data(byte_is_data), .col_inc(col_inc)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_vld) begin
                cap_b[cap_n % 512] = byte_data;
                cap_d[cap_n % 512] = byte_is_data;
                cap_n++;
            end
            if (col_inc) col_n++;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        sdi = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic r);
        rs = r;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        repeat (12) @(negedge clk);
    endtask

    task automatic reselect();
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        cs_n = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // Open a run with length byte len, then expect nrun data bytes and one command.
    task automatic run_test(input logic [7:0] len, input int nrun, input string tag);
        int n0, c0, bad;
        reselect();
        send_byte(8'hE8, 1'b0);
        send_byte(len, 1'b0);
        n0 = cap_n;
        c0 = col_n;
        bad = 0;
        for (int i = 0; i <= nrun; i++) send_byte(8'(i + 8'h20), 1'b0);
        check_eq({tag, " byte count"}, cap_n - n0, nrun + 1);
        for (int i = 0; i < nrun; i++)
            if (cap_d[(n0 + i) % 512] !== 1'b1 || cap_b[(n0 + i) % 512] !== 8'(i + 8'h20)) bad++;
        check_eq({tag, " data bytes tagged"}, bad, 0);
        check_eq({tag, " R7 trailing command"}, int'(cap_d[(n0 + nrun) % 512]), 0);
        check_eq({tag, " R8 col_inc count"}, col_n - c0, nrun);
    endtask

    // {four_pin, rs, byte, expected is_data}
    localparam int NV = 11;
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 1'b1, 8'hA5, 1'b1},
        {1'b1, 1'b0, 8'h3C, 1'b0},
        {1'b1, 1'b1, 8'hE8, 1'b1},
        {1'b1, 1'b0, 8'hE8, 1'b0},
        {1'b0, 1'b0, 8'h12, 1'b0},
        {1'b0, 1'b1, 8'hE8, 1'b0},
        {1'b0, 1'b0, 8'h01, 1'b0},
        {1'b0, 1'b0, 8'hE8, 1'b1},
        {1'b0, 1'b1, 8'h7F, 1'b1},
        {1'b0, 1'b0, 8'h55, 1'b0},
        {1'b0, 1'b1, 8'h99, 1'b0}
    };

    initial begin
        int n0, c0;
        repeat (5) @(negedge clk);
        // R10: reset state
        check_eq("R10 byte_vld", int'(byte_vld), 0);
        check_eq("R10 byte_is_data", int'(byte_is_data), 0);
        check_eq("R10 col_inc", int'(col_inc), 0);
        check_eq("R10 byte_data", int'(byte_data), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        cs_n = 1'b0;
        repeat (10) @(negedge clk);

        // R1 R3 R4 R5 R8: vector walk
        for (int i = 0; i < NV; i++) begin
            four_pin = VEC[i][10];
            n0 = cap_n;
            c0 = col_n;
            send_byte(VEC[i][8:1], VEC[i][9]);
            check_eq($sformatf("R1 vec%0d count", i), cap_n - n0, 1);
            check_eq($sformatf("R1 vec%0d byte", i), int'(cap_b[n0 % 512]), int'(VEC[i][8:1]));
            check_eq($sformatf("R3 R4 R5 vec%0d tag", i), int'(cap_d[n0 % 512]), int'(VEC[i][0]));
            check_eq($sformatf("R8 vec%0d col_inc", i), col_n - c0, int'(VEC[i][0]));
        end

        four_pin = 1'b0;
        run_test(8'h00, 1, "R7 len0");
        run_test(8'h7F, 128, "R6 len127");
        run_test(8'hFF, 128, "R6 len255");

        // R2: abort a partial byte
        reselect();
        n0 = cap_n;
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        check_eq("R2 no byte from partial", cap_n - n0, 0);
        cs_n = 1'b0;
        repeat (10) @(negedge clk);
        send_byte(8'h3C, 1'b0);
        check_eq("R2 fresh byte count", cap_n - n0, 1);
        check_eq("R2 fresh byte value", int'(cap_b[n0 % 512]), 8'h3C);

        // R9: deselect inside a run
        reselect();
        send_byte(8'hE8, 1'b0);
        send_byte(8'h05, 1'b0);
        send_byte(8'h11, 1'b0);
        check_eq("R9 first run byte is data", int'(cap_d[(cap_n - 1) % 512]), 1);
        reselect();
        c0 = col_n;
        send_byte(8'h77, 1'b0);
        check_eq("R9 byte after deselect is command", int'(cap_d[(cap_n - 1) % 512]), 0);
        check_eq("R9 no col_inc after deselect", col_n - c0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule